// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a small 8-bit CPU core and decides which service vector the core fetches next. It gathers five maskable request groups (external pins, core timer, programmable timer, serial port and analog comparator), a reset request and a software-interrupt strobe. Each maskable flag has its own local enable, and all maskable groups are blocked by the global interrupt mask bit. Reset ignores every mask. The software interrupt is taken as part of executing its instruction and is not arbitrated against pending requests.

Maskable requests are evaluated only on clock edges where the core flags an instruction boundary. When a source is taken, the block raises a one-cycle take pulse. The core uses this pulse to set its interrupt mask bit in the same cycle. The block also registers a 16-bit vector address and a 3-bit source code. Both stay frozen until the core acknowledges the vector fetch. Nesting is controlled by the core: a higher-priority request waits while the mask bit is set.

Top module: `intvec_top`

## Requirements
- R1: While `rstN` is low, `takePulse`, `vectorAddr` and `srcCode` are all zero.
- R2: A clock edge with `resetReq` high takes reset: code 0, vector 0x1FFE. This happens with no instruction boundary, whatever the mask bit or local enables, and also while a vector is outstanding.
- R3: If `swiStrobe` is high on an edge with no reset and no outstanding vector, the software interrupt is taken: code 1, vector 0x1FFC. This happens whether `iMask` is high or low and with or without an instruction boundary. It wins over any maskable request.
- R4: A maskable request is taken only on an edge where `instBoundary` is high. A request that rises and falls between boundary edges is never taken.
- R5: While `iMask` is high, no maskable group is taken.
- R6: Each flag counts only when its own enable is high. The groups are formed as follows:
  - external: (`irqPin` and `irqPinEn`) or (any `portPins` bit and `portIrqEn`);
  - core timer: overflow and periodic flags, each with its own enable;
  - programmable timer: capture, match and overflow flags, each with its own enable;
  - serial: one flag with one enable;
  - analog: either `anaFlag` bit, under the single enable `anaEn`.
- R7: When several maskable groups are pending, the one taken follows the fixed order external (code 2), core timer (3), programmable timer (4), serial (5), analog (6). The vector is always 0x1FFE minus twice the code.
- R8: `takePulse` is high for exactly one cycle per take. The core sets its mask bit on it.
- R9: After a take, `vectorAddr` and `srcCode` hold and no software or maskable take occurs until an edge with `fetchAck` high. The next such take can happen at the following edge at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| resetReq | input | 1 | Combined reset request from any reset source |
| swiStrobe | input | 1 | Software-interrupt instruction executing |
| iMask | input | 1 | Global interrupt mask bit |
| instBoundary | input | 1 | Current instruction completes this cycle |
| fetchAck | input | 1 | Core has fetched the outstanding vector |
| irqPin | input | 1 | Dedicated interrupt pin request |
| irqPinEn | input | 1 | Enable for the dedicated pin |
| portPins | input | 4 | Port pin interrupt requests |
| portIrqEn | input | 1 | Shared enable for the port pins |
| ctOvfFlag | input | 1 | Core timer overflow flag |
| ctOvfEn | input | 1 | Enable for core timer overflow |
| periodicFlag | input | 1 | Core timer periodic flag |
| periodicEn | input | 1 | Enable for the periodic flag |
| capFlag | input | 1 | Programmable timer capture flag |
| capEn | input | 1 | Enable for capture |
| matchFlag | input | 1 | Programmable timer compare-match flag |
| matchEn | input | 1 | Enable for compare match |
| ptOvfFlag | input | 1 | Programmable timer overflow flag |
| ptOvfEn | input | 1 | Enable for programmable timer overflow |
| serFlag | input | 1 | Serial transfer flag |
| serEn | input | 1 | Enable for the serial flag |
| anaFlag | input | 2 | Analog comparator flags |
| anaEn | input | 1 | Shared enable for the comparator flags |
| takePulse | output | 1 | One-cycle pulse marking a taken source |
| vectorAddr | output | 16 | Vector address to fetch |
| srcCode | output | 3 | Code of the taken source (0 reset … 6 analog) |

## Verification
The assertions assume that all inputs are synchronous to `clk` and stable around its rising edge. They also assume that `iMask` is whatever the core drives; the bench does not set it automatically after a take. The bench changes every input only on falling edges and raises `fetchAck` for single cycles. It holds requests across boundary edges or removes them between boundaries as each scenario requires. Because the behavioural model decides the expected take on its own, combinations such as a reset during an outstanding vector or a software strobe under a set mask are compared just like ordinary takes.

// File: rtl/intvec_pkg.sv
package intvec_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RST  = 2'd1,
    SEL_SWI  = 2'd2,
    SEL_MASK = 2'd3
  } selKind_e;

  typedef struct packed {
    logic     load;
    selKind_e kind;
  } ctlStrb_t;

  localparam int CODE_RST   = 0;
  localparam int CODE_SWI   = 1;
  localparam int FIRST_MASK = 2;

endpackage

// File: rtl/intvec_ctrl.sv
module intvec_ctrl
  import intvec_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     resetReq,
  input  logic     swiStrobe,
  input  logic     iMask,
  input  logic     instBoundary,
  input  logic     anyMaskReq,
  input  logic     fetchAck,
  output ctlStrb_t strb,
  output logic     takePulse,
  output logic     busy
);

  logic busyQ;

  always_comb begin
    strb = '{load: 1'b0, kind: SEL_NONE};
    if (resetReq) begin
      strb = '{load: 1'b1, kind: SEL_RST};
    end else if (!busyQ) begin
      if (swiStrobe) begin
        strb = '{load: 1'b1, kind: SEL_SWI};
      end else if (instBoundary && !iMask && anyMaskReq) begin
        strb = '{load: 1'b1, kind: SEL_MASK};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takePulse <= 1'b0;
      busyQ     <= 1'b0;
    end else begin
      takePulse <= strb.load;
      if (strb.load)     busyQ <= 1'b1;
      else if (fetchAck) busyQ <= 1'b0;
    end
  end

  assign busy = busyQ;

  // R8: without a fresh reset the pulse ends after one cycle
  p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (takePulse && !resetReq) |=> !takePulse);

  // R3: software strobe is taken whenever idle and no reset
  p_swi_take_r3: assert property (@(posedge clk) disable iff (!rstN)
    (swiStrobe && !resetReq && !busyQ) |=> takePulse);

endmodule

// File: rtl/intvec_dp.sv
module intvec_dp
  import intvec_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter int                CODE_W  = 3,
  parameter int                PORT_N  = 4,
  parameter int                ANA_N   = 2,
  parameter logic [ADDR_W-1:0] VEC_TOP = 16'h1FFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic              irqPin,
  input  logic              irqPinEn,
  input  logic [PORT_N-1:0] portPins,
  input  logic              portIrqEn,
  input  logic              ctOvfFlag,
  input  logic              ctOvfEn,
  input  logic              periodicFlag,
  input  logic              periodicEn,
  input  logic              capFlag,
  input  logic              capEn,
  input  logic              matchFlag,
  input  logic              matchEn,
  input  logic              ptOvfFlag,
  input  logic              ptOvfEn,
  input  logic              serFlag,
  input  logic              serEn,
  input  logic [ANA_N-1:0]  anaFlag,
  input  logic              anaEn,
  output logic              anyMaskReq,
  output logic [ADDR_W-1:0] vectorAddr,
  output logic [CODE_W-1:0] srcCode
);

  localparam int NUM_GROUPS = 5;

  logic [NUM_GROUPS-1:0] groupReq;
  logic [CODE_W-1:0]     winCode;
  logic [CODE_W-1:0]     selCode;

  // bit 0 is the highest priority group
  assign groupReq[0] = (irqPin & irqPinEn) | ((|portPins) & portIrqEn);
  assign groupReq[1] = (ctOvfFlag & ctOvfEn) | (periodicFlag & periodicEn);
  assign groupReq[2] = (capFlag & capEn) | (matchFlag & matchEn) | (ptOvfFlag & ptOvfEn);
  assign groupReq[3] = serFlag & serEn;
  assign groupReq[4] = (|anaFlag) & anaEn;

  assign anyMaskReq = |groupReq;

  always_comb begin
    winCode = CODE_W'(FIRST_MASK);
    for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
      if (groupReq[g]) winCode = CODE_W'(FIRST_MASK + g);
    end
  end

  always_comb begin
    case (strb.kind)
      SEL_RST: selCode = CODE_W'(CODE_RST);
      SEL_SWI: selCode = CODE_W'(CODE_SWI);
      default: selCode = winCode;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vectorAddr <= '0;
      srcCode    <= '0;
    end else if (strb.load) begin
      srcCode    <= selCode;
      vectorAddr <= VEC_TOP - (ADDR_W'(selCode) << 1);
    end
  end

  // R7: a maskable load never selects a group that is not pending
  p_win_pending_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.kind == SEL_MASK) |-> groupReq[winCode - CODE_W'(FIRST_MASK)]);

endmodule

// File: rtl/intvec_top.sv
module intvec_top
  import intvec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        resetReq,
  input  logic        swiStrobe,
  input  logic        iMask,
  input  logic        instBoundary,
  input  logic        fetchAck,
  input  logic        irqPin,
  input  logic        irqPinEn,
  input  logic [3:0]  portPins,
  input  logic        portIrqEn,
  input  logic        ctOvfFlag,
  input  logic        ctOvfEn,
  input  logic        periodicFlag,
  input  logic        periodicEn,
  input  logic        capFlag,
  input  logic        capEn,
  input  logic        matchFlag,
  input  logic        matchEn,
  input  logic        ptOvfFlag,
  input  logic        ptOvfEn,
  input  logic        serFlag,
  input  logic        serEn,
  input  logic [1:0]  anaFlag,
  input  logic        anaEn,
  output logic        takePulse,
  output logic [15:0] vectorAddr,
  output logic [2:0]  srcCode
);

  localparam int          ADDR_W  = 16;
  localparam int          CODE_W  = 3;
  localparam logic [15:0] VEC_TOP = 16'h1FFE;

  ctlStrb_t strb;
  logic     anyMaskReq;
  logic     busy;

  intvec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .swiStrobe(swiStrobe),
    .iMask(iMask), .instBoundary(instBoundary), .anyMaskReq(anyMaskReq),
    .fetchAck(fetchAck), .strb(strb), .takePulse(takePulse), .busy(busy)
  );

  intvec_dp #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .PORT_N(4), .ANA_N(2), .VEC_TOP(VEC_TOP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .irqPin(irqPin), .irqPinEn(irqPinEn), .portPins(portPins), .portIrqEn(portIrqEn),
    .ctOvfFlag(ctOvfFlag), .ctOvfEn(ctOvfEn), .periodicFlag(periodicFlag),
    .periodicEn(periodicEn), .capFlag(capFlag), .capEn(capEn),
    .matchFlag(matchFlag), .matchEn(matchEn), .ptOvfFlag(ptOvfFlag), .ptOvfEn(ptOvfEn),
    .serFlag(serFlag), .serEn(serEn), .anaFlag(anaFlag), .anaEn(anaEn),
    .anyMaskReq(anyMaskReq), .vectorAddr(vectorAddr), .srcCode(srcCode)
  );

  // R2: reset request always lands on the reset vector
  p_reset_take_r2: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> (takePulse && srcCode == 3'd0 && vectorAddr == VEC_TOP));

  // R4, R5: maskable takes need a boundary edge with the mask clear
  p_mask_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (takePulse && srcCode >= 3'd2) |-> $past(!iMask && instBoundary));

  // R7: vector and code agree at every take
  p_vec_enc_r7: assert property (@(posedge clk) disable iff (!rstN)
    takePulse |-> (vectorAddr == VEC_TOP - (ADDR_W'(srcCode) << 1)));

  // R9: while a vector is outstanding only reset may replace it
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !resetReq) |=> ($stable(vectorAddr) && $stable(srcCode) && !takePulse));

endmodule

// File: tb/intvec_top_bench.sv
module intvec_top_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resetReq = 0, swiStrobe = 0, iMask = 0, instBoundary = 0, fetchAck = 0;
  logic irqPin = 0, irqPinEn = 0, portIrqEn = 0;
  logic [3:0] portPins = '0;
  logic ctOvfFlag = 0, ctOvfEn = 0, periodicFlag = 0, periodicEn = 0;
  logic capFlag = 0, capEn = 0, matchFlag = 0, matchEn = 0, ptOvfFlag = 0, ptOvfEn = 0;
  logic serFlag = 0, serEn = 0, anaEn = 0;
  logic [1:0] anaFlag = '0;
  logic takePulse;
  logic [15:0] vectorAddr;
  logic [2:0] srcCode;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  intvec_top u_intvec_top (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .swiStrobe(swiStrobe), .iMask(iMask),
    .instBoundary(instBoundary), .fetchAck(fetchAck), .irqPin(irqPin), .irqPinEn(irqPinEn),
    .portPins(portPins), .portIrqEn(portIrqEn), .ctOvfFlag(ctOvfFlag), .ctOvfEn(ctOvfEn),
    .periodicFlag(periodicFlag), .periodicEn(periodicEn), .capFlag(capFlag), .capEn(capEn),
    .matchFlag(matchFlag), .matchEn(matchEn), .ptOvfFlag(ptOvfFlag), .ptOvfEn(ptOvfEn),
    .serFlag(serFlag), .serEn(serEn), .anaFlag(anaFlag), .anaEn(anaEn),
    .takePulse(takePulse), .vectorAddr(vectorAddr), .srcCode(srcCode)
  );

  // behavioural reference model
  bit mBusy = 0, mTake = 0;
  int mCode = 0;
  int mVec = 0;

  function automatic int pendingCode();
    if ((irqPin && irqPinEn) || (portPins != 0 && portIrqEn)) return 2;
    if ((ctOvfFlag && ctOvfEn) || (periodicFlag && periodicEn)) return 3;
    if ((capFlag && capEn) || (matchFlag && matchEn) || (ptOvfFlag && ptOvfEn)) return 4;
    if (serFlag && serEn) return 5;
    if (anaFlag != 0 && anaEn) return 6;
    return -1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mTake = 0; mCode = 0; mVec = 0;
    end else begin
      int pc;
      int newCode;
      pc = pendingCode();
      newCode = -1;
      if (resetReq) newCode = 0;
      else if (!mBusy) begin
        if (swiStrobe) newCode = 1;
        else if (instBoundary && !iMask && pc >= 0) newCode = pc;
      end else if (fetchAck) mBusy = 0;
      mTake = (newCode >= 0);
      if (mTake) begin
        mBusy = 1;
        mCode = newCode;
        mVec = 'h1FFE - 2 * newCode;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      tests++;
      if (takePulse !== mTake || srcCode !== 3'(mCode) || vectorAddr !== 16'(mVec)) begin
        fails++;
        $display("FAIL %s: take=%0b code=%0d vec=%h expected take=%0b code=%0d vec=%h",
                 curReq, takePulse, srcCode, vectorAddr, mTake, mCode, 16'(mVec));
      end
    end
  end

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 50000", cycles);
      report();
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack();
    fetchAck = 1; tick(1); fetchAck = 0;
  endtask

  task automatic boundary();
    instBoundary = 1; tick(1); instBoundary = 0;
  endtask

  task automatic clearReq();
    irqPin = 0; portPins = '0; ctOvfFlag = 0; periodicFlag = 0; capFlag = 0;
    matchFlag = 0; ptOvfFlag = 0; serFlag = 0; anaFlag = '0;
  endtask

  task automatic setEn(bit v);
    irqPinEn = v; portIrqEn = v; ctOvfEn = v; periodicEn = v; capEn = v;
    matchEn = v; ptOvfEn = v; serEn = v; anaEn = v;
  endtask

  task automatic setFlag(int which);
    case (which)
      0: irqPin = 1;       1: portPins[2] = 1;  2: ctOvfFlag = 1;
      3: periodicFlag = 1; 4: capFlag = 1;      5: matchFlag = 1;
      6: ptOvfFlag = 1;    7: serFlag = 1;      8: anaFlag[0] = 1;
      default: anaFlag[1] = 1;
    endcase
  endtask

  task automatic setOwnEn(int which);
    case (which)
      0: irqPinEn = 1;   1: portIrqEn = 1; 2: ctOvfEn = 1;
      3: periodicEn = 1; 4: capEn = 1;     5: matchEn = 1;
      6: ptOvfEn = 1;    7: serEn = 1;     default: anaEn = 1;
    endcase
  endtask

  initial begin
    int expCode[10] = '{2, 2, 3, 3, 4, 4, 4, 5, 6, 6};
    tick(3);
    chk("R1 take", int'(takePulse), 0);
    chk("R1 vec", int'(vectorAddr), 0);
    chk("R1 code", int'(srcCode), 0);
    rstN = 1;
    tick(2);

    // each flag with only the other enables set: never taken
    curReq = "R6";
    for (int f = 0; f < 10; f++) begin
      setEn(1);
      case (f)
        0: irqPinEn = 0;   1: portIrqEn = 0; 2: ctOvfEn = 0; 3: periodicEn = 0;
        4: capEn = 0;      5: matchEn = 0;   6: ptOvfEn = 0; 7: serEn = 0;
        default: anaEn = 0;
      endcase
      setFlag(f);
      boundary();
      chk("R6 disabled flag", int'(takePulse), 0);
      clearReq(); setEn(0);
    end

    // each flag alone with its own enable
    curReq = "R7";
    for (int f = 0; f < 10; f++) begin
      setOwnEn(f); setFlag(f);
      boundary();
      chk("R6 enabled flag take", int'(takePulse), 1);
      chk("R7 single code", int'(srcCode), expCode[f]);
      clearReq(); setEn(0);
      tick(1);
      chk("R8 pulse ends", int'(takePulse), 0);
      ack();
    end

    // all groups pending, peel off winners
    for (int f = 0; f < 10; f++) setFlag(f);
    setEn(1);
    for (int g = 2; g <= 6; g++) begin
      boundary();
      chk("R7 priority code", int'(srcCode), g);
      chk("R7 priority vec", int'(vectorAddr), 'h1FFE - 2 * g);
      case (g)
        2: begin irqPin = 0; portPins = '0; end
        3: begin ctOvfFlag = 0; periodicFlag = 0; end
        4: begin capFlag = 0; matchFlag = 0; ptOvfFlag = 0; end
        5: serFlag = 0;
        default: anaFlag = '0;
      endcase
      ack();
    end

    // global mask blocks everything maskable
    curReq = "R5";
    for (int f = 0; f < 10; f++) setFlag(f);
    iMask = 1;
    boundary(); boundary();
    chk("R5 masked", int'(takePulse), 0);

    // software interrupt ignores the mask and boundary, beats maskables
    curReq = "R3";
    swiStrobe = 1; tick(1); swiStrobe = 0;
    chk("R3 swi masked", int'(srcCode), 1);
    chk("R3 swi vec", int'(vectorAddr), 'h1FFC);
    ack();
    iMask = 0;
    swiStrobe = 1; instBoundary = 1; tick(1); swiStrobe = 0; instBoundary = 0;
    chk("R3 swi over maskable", int'(srcCode), 1);
    ack();
    clearReq();

    // requests between boundaries
    curReq = "R4";
    serFlag = 1; tick(3); serFlag = 0; tick(2);
    boundary();
    chk("R4 vanished request", int'(takePulse), 0);
    capFlag = 1; tick(3);
    chk("R4 no take before boundary", int'(takePulse), 0);
    boundary();
    chk("R4 take at boundary", int'(srcCode), 4);
    capFlag = 0;

    // outstanding vector holds until acknowledged
    curReq = "R9";
    irqPin = 1; swiStrobe = 1; boundary(); swiStrobe = 0; boundary();
    chk("R9 hold code", int'(srcCode), 4);
    chk("R9 no new take", int'(takePulse), 0);
    ack();
    boundary();
    chk("R9 pending after ack", int'(srcCode), 2);
    irqPin = 0;

    // reset overrides busy, mask and missing boundary
    curReq = "R2";
    iMask = 1; resetReq = 1; tick(1);
    chk("R2 reset code", int'(srcCode), 0);
    chk("R2 reset vec", int'(vectorAddr), 'h1FFE);
    tick(1); resetReq = 0; tick(1);
    chk("R8 after reset", int'(takePulse), 0);
    ack(); iMask = 0; setEn(0);
    tick(3);
    report();
  end

endmodule